// File: doc/BRIEF.md
# Page-Indexed Peripheral Address Router

This block sits at the entrance of a peripheral window in an on-chip interconnect. It decides which of several target ports receives each CPU access that lands in the window. It does not compare the address against fixed ranges. It keeps a routing table with one entry per page of the window. For each page, an entry holds a separate target for byte, halfword and word accesses.

Software attaches a target to a region through a configuration port. It gives the region's byte offset from the window base, the region's length in bytes, a target number and a mask of the access sizes to route. The control logic then writes the target into one page entry per cycle. It starts at the page that holds the offset and continues until the region's length is covered. It stops early if it reaches the last page of the window. A later attach that covers the same pages overwrites them.

For each access, the block subtracts the window base and shifts right by the page-size bit count to get a page index. It reads that page's entry for the access size and forwards the request to the chosen target one cycle later. An access to an empty entry, with the reserved size code, or outside the window raises a decode-error response instead.

Top module: `pgroute`

## Requirements
- R1: After reset every table entry is empty, so any access raises a decode error. `cfgReady` is high, and `fwdValid`, `decErr` and `cfgErr` are low.
- R2: An access with `reqValid` high is answered exactly one cycle later. The page index is (`reqAddr` − `WIN_BASE`) >> `PAGE_BITS`. On a hit, `fwdValid` is high, `fwdTarget` is the stored target, and `fwdAddr` and `fwdSize` are copies of the request.
- R3: An attach covers ceil(`cfgBytes` / page size) consecutive pages, starting with page `cfgOffset` >> `PAGE_BITS`. The page just after the region stays empty.
- R4: Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = reserved. Bit s of `cfgSizeMask` selects whether size code s is written. An access whose size is not routed on its page raises `decErr`, and so does any access with code 3.
- R5: An attach whose offset is not below the window size, or whose length is zero, is rejected. `cfgErr` pulses for one cycle after the offer, no entry changes, and `cfgReady` stays high.
- R6: Where regions overlap, the most recently attached region owns the shared pages. The earlier region keeps its pages outside the overlap.
- R7: An access below `WIN_BASE`, or at or above `WIN_BASE` + `WIN_SIZE`, raises `decErr` and never `fwdValid`.
- R8: An accepted attach holds `cfgReady` low for one cycle per page written. An attach offered while `cfgReady` is low is ignored.
- R9: A region that runs past the end of the window fills pages only up to the last page of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Attach request offered |
| cfgReady | output | 1 | Control is idle and takes an attach |
| cfgOffset | input | ADDR_W | Region byte offset from window base |
| cfgBytes | input | ADDR_W | Region length in bytes |
| cfgTarget | input | TGT_W | Target port number for the region |
| cfgSizeMask | input | 3 | Access sizes to route (bit0 byte, bit1 half, bit2 word) |
| cfgErr | output | 1 | One-cycle pulse when an attach is rejected |
| reqValid | input | 1 | Access request valid |
| reqAddr | input | ADDR_W | Access address |
| reqSize | input | 2 | Access size code |
| fwdValid | output | 1 | Access forwarded to a target |
| fwdTarget | output | TGT_W | Selected target port |
| fwdAddr | output | ADDR_W | Forwarded address |
| fwdSize | output | 2 | Forwarded size code |
| decErr | output | 1 | Decode-error response |

## Verification
A wrong fill pointer or a wrong remaining-page count shows at the ports as soon as the fill ends, in two ways. `cfgReady` returns early or late, and an access probed one page past a region's edge comes back with the wrong answer. A table entry with the wrong valid bit or target for one size shows on the first access of that size to that page, one cycle after the request. Checks on overlap, clipping at the window end and rejected offers find lost or stray writes, which show up only when a later probe reads the affected page.

// File: rtl/pgroute_pkg.sv
package pgroute_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  localparam int NUM_SIZES = 3;

  // strobes from control to the table datapath
  typedef struct packed {
    logic                 wrEn;
    logic [NUM_SIZES-1:0] wrMask;
  } fillStrobe_t;

endpackage

// File: rtl/pgroute_ctrl.sv
module pgroute_ctrl
  import pgroute_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TGT_W     = 3,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 180,
  parameter int IDX_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  output logic                 cfgReady,
  input  logic [ADDR_W-1:0]    cfgOffset,
  input  logic [ADDR_W-1:0]    cfgBytes,
  input  logic [TGT_W-1:0]     cfgTarget,
  input  logic [NUM_SIZES-1:0] cfgSizeMask,
  output logic                 cfgErr,
  output fillStrobe_t          fillStb,
  output logic [IDX_W-1:0]     wrPage,
  output logic [TGT_W-1:0]     wrTarget
);

  localparam int RW = ADDR_W - PAGE_BITS + 1;
  localparam logic [ADDR_W:0] PAGE_M1 = (ADDR_W+1)'((1 << PAGE_BITS) - 1);
  localparam logic [ADDR_W-1:0] LAST_PAGE = ADDR_W'(NUM_PAGES - 1);
  localparam logic [ADDR_W-1:0] PAGES_A = ADDR_W'(NUM_PAGES);

  typedef enum logic {ST_IDLE, ST_FILL} state_e;

  state_e               stateQ;
  logic [ADDR_W-1:0]    curPageQ;
  logic [RW-1:0]        remainQ;
  logic [TGT_W-1:0]     tgtQ;
  logic [NUM_SIZES-1:0] maskQ;
  logic                 errQ;

  logic [ADDR_W-1:0] firstPage;
  logic [ADDR_W:0]   roundUp;
  logic [RW-1:0]     pageCount;
  logic              offerTaken;
  logic              legal;
  logic              lastWrite;

  assign firstPage  = cfgOffset >> PAGE_BITS;
  assign roundUp    = {1'b0, cfgBytes} + PAGE_M1;
  assign pageCount  = roundUp[PAGE_BITS +: RW];
  assign legal      = (firstPage < PAGES_A) && (cfgBytes != '0);
  assign offerTaken = cfgValid && (stateQ == ST_IDLE);
  assign lastWrite  = (remainQ == RW'(1)) || (curPageQ == LAST_PAGE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      curPageQ <= '0;
      remainQ  <= '0;
      tgtQ     <= '0;
      maskQ    <= '0;
      errQ     <= 1'b0;
    end else begin
      errQ <= offerTaken && !legal;
      case (stateQ)
        ST_IDLE: if (offerTaken && legal) begin
          stateQ   <= ST_FILL;
          curPageQ <= firstPage;
          remainQ  <= pageCount;
          tgtQ     <= cfgTarget;
          maskQ    <= cfgSizeMask;
        end
        ST_FILL: begin
          curPageQ <= curPageQ + ADDR_W'(1);
          remainQ  <= remainQ - RW'(1);
          if (lastWrite) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign cfgReady       = (stateQ == ST_IDLE);
  assign cfgErr         = errQ;
  assign fillStb.wrEn   = (stateQ == ST_FILL);
  assign fillStb.wrMask = maskQ;
  assign wrPage         = curPageQ[IDX_W-1:0];
  assign wrTarget       = tgtQ;

  // consecutive writes of one fill step by exactly one page
  assert_page_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fillStb.wrEn && $past(fillStb.wrEn)) |-> (wrPage == $past(wrPage) + IDX_W'(1)));

  // fill never writes beyond the window's last page
  assert_page_in_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    fillStb.wrEn |-> (curPageQ < PAGES_A));

  // a rejection leaves control idle
  assert_reject_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> cfgReady);

  // an offer while busy starts nothing new: the fill either goes on or ends
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fillStb.wrEn && cfgValid) |=> (!cfgErr));

endmodule

// File: rtl/pgroute_table.sv
module pgroute_table
  import pgroute_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                TGT_W     = 3,
  parameter int                PAGE_BITS = 12,
  parameter int                NUM_PAGES = 180,
  parameter int                IDX_W     = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h4800_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h000B_4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobe_t       fillStb,
  input  logic [IDX_W-1:0]  wrPage,
  input  logic [TGT_W-1:0]  wrTarget,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output logic              fwdValid,
  output logic [TGT_W-1:0]  fwdTarget,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [1:0]        fwdSize,
  output logic              decErr
);

  logic [NUM_SIZES-1:0]       validQ [NUM_PAGES];
  logic [NUM_SIZES*TGT_W-1:0] tgtQ   [NUM_PAGES];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[p] <= '0;
        tgtQ[p]   <= '0;
      end else if (fillStb.wrEn && (wrPage == IDX_W'(p))) begin
        for (int s = 0; s < NUM_SIZES; s++) begin
          if (fillStb.wrMask[s]) begin
            validQ[p][s]              <= 1'b1;
            tgtQ[p][s*TGT_W +: TGT_W] <= wrTarget;
          end
        end
      end
    end
  end

  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  pageIdx;
  logic              inWin;
  logic              sizeOk;
  logic              hit;
  logic [TGT_W-1:0]  hitTarget;

  assign offset  = reqAddr - WIN_BASE;
  assign inWin   = (reqAddr >= WIN_BASE) && (offset < WIN_SIZE);
  assign pageIdx = offset[PAGE_BITS +: IDX_W];
  assign sizeOk  = (reqSize != SZ_RSVD);

  always_comb begin
    hit       = 1'b0;
    hitTarget = '0;
    if (inWin && sizeOk && (pageIdx < IDX_W'(NUM_PAGES))) begin
      hit       = validQ[pageIdx][reqSize];
      hitTarget = tgtQ[pageIdx][reqSize*TGT_W +: TGT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid  <= 1'b0;
      decErr    <= 1'b0;
      fwdTarget <= '0;
      fwdAddr   <= '0;
      fwdSize   <= '0;
    end else begin
      fwdValid  <= reqValid && hit;
      decErr    <= reqValid && !hit;
      fwdTarget <= hit ? hitTarget : '0;
      fwdAddr   <= reqAddr;
      fwdSize   <= reqSize;
    end
  end

  // a response of either kind answers a request of the previous cycle
  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid || decErr) |-> $past(reqValid));

  // forward and error never together
  assert_resp_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && decErr));

  // reserved size never reaches a target
  assert_no_rsvd_fwd_R4: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (fwdSize != SZ_RSVD));

  // an out-of-window request is never forwarded
  assert_outside_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !inWin) |=> (decErr && !fwdValid));

endmodule

// File: rtl/pgroute.sv
module pgroute
  import pgroute_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                NUM_TGT   = 8,
  parameter int                PAGE_BITS = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h4800_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h000B_4000,
  localparam int               TGT_W     = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  output logic              cfgReady,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic [ADDR_W-1:0] cfgBytes,
  input  logic [TGT_W-1:0]  cfgTarget,
  input  logic [2:0]        cfgSizeMask,
  output logic              cfgErr,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output logic              fwdValid,
  output logic [TGT_W-1:0]  fwdTarget,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [1:0]        fwdSize,
  output logic              decErr
);

  localparam int NUM_PAGES = int'(WIN_SIZE >> PAGE_BITS);
  localparam int IDX_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  fillStrobe_t      fillStb;
  logic [IDX_W-1:0] wrPage;
  logic [TGT_W-1:0] wrTarget;

  pgroute_ctrl #(
    .ADDR_W(ADDR_W), .TGT_W(TGT_W), .PAGE_BITS(PAGE_BITS),
    .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgReady(cfgReady),
    .cfgOffset(cfgOffset), .cfgBytes(cfgBytes),
    .cfgTarget(cfgTarget), .cfgSizeMask(cfgSizeMask),
    .cfgErr(cfgErr),
    .fillStb(fillStb), .wrPage(wrPage), .wrTarget(wrTarget)
  );

  pgroute_table #(
    .ADDR_W(ADDR_W), .TGT_W(TGT_W), .PAGE_BITS(PAGE_BITS),
    .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W),
    .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
  ) table_i (
    .clk(clk), .rstN(rstN),
    .fillStb(fillStb), .wrPage(wrPage), .wrTarget(wrTarget),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .fwdValid(fwdValid), .fwdTarget(fwdTarget), .fwdAddr(fwdAddr),
    .fwdSize(fwdSize), .decErr(decErr)
  );

endmodule

// File: tb/pgroute_tb_top.sv
`timescale 1ns/1ps
module pgroute_tb_top;

  localparam logic [31:0] BASE = 32'h4800_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0;
  logic        cfgReady;
  logic [31:0] cfgOffset = '0;
  logic [31:0] cfgBytes = '0;
  logic [2:0]  cfgTarget = '0;
  logic [2:0]  cfgSizeMask = '0;
  logic        cfgErr;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        fwdValid;
  logic [2:0]  fwdTarget;
  logic [31:0] fwdAddr;
  logic [1:0]  fwdSize;
  logic        decErr;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  pgroute dut_i (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgReady(cfgReady),
    .cfgOffset(cfgOffset), .cfgBytes(cfgBytes),
    .cfgTarget(cfgTarget), .cfgSizeMask(cfgSizeMask), .cfgErr(cfgErr),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .fwdValid(fwdValid), .fwdTarget(fwdTarget), .fwdAddr(fwdAddr),
    .fwdSize(fwdSize), .decErr(decErr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // offer an attach; returns cfgErr seen and cycles with cfgReady low
  task automatic attach(input logic [31:0] off, input logic [31:0] len,
                        input logic [2:0] tgt, input logic [2:0] mask,
                        output int errSeen, output int busyCycles);
    @(negedge clk);
    cfgValid = 1'b1; cfgOffset = off; cfgBytes = len;
    cfgTarget = tgt; cfgSizeMask = mask;
    @(negedge clk);
    cfgValid = 1'b0;
    errSeen = int'(cfgErr);
    busyCycles = 0;
    while (!cfgReady && busyCycles < 400) begin
      busyCycles++;
      @(negedge clk);
    end
  endtask

  // one access; expTgt < 0 means a decode error is expected
  task automatic probe(input string req, input logic [31:0] addr,
                       input logic [1:0] sz, input int expTgt);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSize = sz;
    @(negedge clk);
    reqValid = 1'b0;
    if (expTgt < 0) begin
      check(req, "decErr", int'(decErr), 1);
      check(req, "fwdValid", int'(fwdValid), 0);
    end else begin
      check(req, "fwdValid", int'(fwdValid), 1);
      check(req, "fwdTarget", int'(fwdTarget), expTgt);
      check(req, "fwdAddr", int'(fwdAddr), int'(addr));
      check(req, "fwdSize", int'(fwdSize), int'(sz));
    end
    @(negedge clk);
    check(req, "idle after response", int'(fwdValid | decErr), 0);
  endtask

  task automatic test_reset_r1();
    check("R1", "cfgReady", int'(cfgReady), 1);
    check("R1", "fwdValid", int'(fwdValid), 0);
    check("R1", "decErr", int'(decErr), 0);
    check("R1", "cfgErr", int'(cfgErr), 0);
    probe("R1", BASE, 2'd2, -1);
    probe("R1", BASE + 32'h5_0000, 2'd0, -1);
  endtask

  task automatic test_basic_r2_r3_r8();
    int e, b;
    attach(32'h2000, 32'h3000, 3'd5, 3'b111, e, b);
    check("R8", "busy cycles 3 pages", b, 3);
    check("R5", "no error legal attach", e, 0);
    probe("R2", BASE + 32'h2000, 2'd2, 5);
    probe("R2", BASE + 32'h3010, 2'd0, 5);
    probe("R3", BASE + 32'h4FFE, 2'd1, 5);
    probe("R3", BASE + 32'h5000, 2'd2, -1);
    probe("R3", BASE + 32'h1FFF, 2'd0, -1);
    attach(32'h1_0000, 32'h1001, 3'd2, 3'b111, e, b);
    check("R3", "busy cycles rounded up", b, 2);
    probe("R3", BASE + 32'h1_1FFC, 2'd2, 2);
    probe("R3", BASE + 32'h1_2000, 2'd2, -1);
  endtask

  task automatic test_size_mask_r4();
    int e, b;
    attach(32'h2_0000, 32'h1000, 3'd3, 3'b100, e, b);
    probe("R4", BASE + 32'h2_0004, 2'd2, 3);
    probe("R4", BASE + 32'h2_0004, 2'd0, -1);
    probe("R4", BASE + 32'h2_0004, 2'd1, -1);
    probe("R4", BASE + 32'h2000, 2'd3, -1);
    attach(32'h2_0000, 32'h1000, 3'd7, 3'b001, e, b);
    probe("R4", BASE + 32'h2_0008, 2'd0, 7);
    probe("R4", BASE + 32'h2_0008, 2'd2, 3);
  endtask

  task automatic test_overlap_r6();
    int e, b;
    attach(32'h3000, 32'h1000, 3'd6, 3'b111, e, b);
    probe("R6", BASE + 32'h3000, 2'd2, 6);
    probe("R6", BASE + 32'h2000, 2'd2, 5);
    probe("R6", BASE + 32'h4000, 2'd1, 5);
  endtask

  task automatic test_reject_r5();
    int e, b;
    attach(32'h000B_4000, 32'h1000, 3'd1, 3'b111, e, b);
    check("R5", "cfgErr offset beyond window", e, 1);
    check("R5", "no busy on reject", b, 0);
    attach(32'h0000_6000, 32'h0, 3'd1, 3'b111, e, b);
    check("R5", "cfgErr zero length", e, 1);
    check("R5", "no busy zero length", b, 0);
    probe("R5", BASE + 32'h6000, 2'd2, -1);
    check("R5", "cfgErr is one pulse", int'(cfgErr), 0);
  endtask

  task automatic test_window_r7_r9();
    int e, b;
    attach(32'h000B_3000, 32'h4000, 3'd1, 3'b111, e, b);
    check("R9", "busy clipped to 1", b, 1);
    check("R9", "no error", e, 0);
    probe("R9", BASE + 32'h000B_3FFC, 2'd2, 1);
    probe("R7", BASE + 32'h000B_4000, 2'd2, -1);
    probe("R7", BASE - 32'd4, 2'd2, -1);
    probe("R7", 32'h0000_2000, 2'd2, -1);
  endtask

  task automatic test_busy_ignore_r8();
    int b;
    @(negedge clk);
    cfgValid = 1'b1; cfgOffset = 32'h3_0000; cfgBytes = 32'h2000;
    cfgTarget = 3'd4; cfgSizeMask = 3'b111;
    @(negedge clk);
    check("R8", "ready low in fill", int'(cfgReady), 0);
    cfgOffset = 32'h4_0000; cfgTarget = 3'd7;
    @(negedge clk);
    cfgValid = 1'b0;
    b = 0;
    while (!cfgReady && b < 400) begin b++; @(negedge clk); end
    @(negedge clk);
    check("R8", "ready back high", int'(cfgReady), 1);
    probe("R8", BASE + 32'h3_1000, 2'd2, 4);
    probe("R8", BASE + 32'h4_0000, 2'd2, -1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset_r1();
    test_basic_r2_r3_r8();
    test_size_mask_r4();
    test_overlap_r6();
    test_reject_r5();
    test_window_r7_r9();
    test_busy_ignore_r8();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule